// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a read or write command into the stream of column addresses that a synchronous DRAM burst visits. The command carries a start column. The block takes the burst length, the wrap order and the single-write option from its configuration inputs, captures them with the command, and presents one column per clock from the next cycle on. Bursts of 1, 2, 4 or 8 beats stay inside the aligned window that holds the start column. They visit it in ascending order with wrap-around, or in interleaved order. A full-page burst walks the whole row and wraps at its end. It stops only when a new command arrives.

A new command is accepted on any clock. It ends the running burst at once, so the controller can issue random columns back to back. Two outputs go to the controller. A burst-active flag marks every cycle that carries a valid column. A last-beat pulse marks the final beat of a bounded burst, so that auto-precharge can be started at the right moment. The data width of the device is a parameter, and it sets the column width: 10 bits for x4, 9 for x8 and 8 for x16.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is low and after it is released, until the first command, burstActive and lastBeat are 0 and colOut is 0.
- R2: The column width is 10 bits when DQ_WIDTH is 4, 9 bits when it is 8 and 8 bits when it is 16. Full-page addresses wrap modulo 2 to the power of that width.
- R3: A command is sampled when cmdValid is 1 at a rising edge. Beat 0 equals cmdCol and appears after that edge. Beat n appears n cycles later. cfgBurstLen selects the length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The length, wrap and single-write settings are captured with the command, and later changes do not affect that burst.
- R4: When cfgInterleave is 0, a burst of BL beats keeps the column bits above log2(BL) fixed. Its low log2(BL) bits count up from the start value modulo BL.
- R5: When cfgInterleave is 1, beat n of a 2, 4 or 8 beat burst has low log2(BL) bits equal to the start column's low bits XOR n. The upper bits stay fixed.
- R6: A full-page burst adds n to the start column modulo the page size, and cfgInterleave has no effect on it. lastBeat is never raised, and the burst runs until the next command.
- R7: A command that arrives during a burst ends that burst. From the next cycle the outputs follow the new command, and one command per clock is accepted.
- R8: When cfgSingleWrite is 1, a write command (cmdWrite = 1) gives a single beat whatever the length setting. Read commands, and writes while cfgSingleWrite is 0, use the programmed length.
- R9: The unused length codes 3'b100, 3'b101 and 3'b110 give a single beat.
- R10: lastBeat is 1 only on the final beat of a bounded burst. burstActive is 1 on every beat and falls in the cycle after the final beat unless a new command was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | A read or write command with a column is presented |
| cmdWrite | input | 1 | 1 for a write command, 0 for a read |
| cmdCol | input | COL_W | Start column of the command |
| cfgBurstLen | input | 3 | Burst length code |
| cfgInterleave | input | 1 | 0 for sequential order, 1 for interleaved order |
| cfgSingleWrite | input | 1 | Writes are single-beat when 1 |
| colOut | output | COL_W | Column of the current beat |
| burstActive | output | 1 | colOut carries a valid beat |
| lastBeat | output | 1 | Final beat of a bounded burst |

## Verification
Starts near the top of the window and at the top of the page are the main cases. A design that carried from the low bits into the upper bits would leave the aligned window, and one that failed to wrap would run off the page. Interleaved starts at odd offsets separate XOR from addition, which a mixed-up design would repeat. Commands are also issued mid-burst and on every clock, to catch a generator that finishes the old burst or drops a command. Further tests change the configuration during a burst, issue single-beat writes and use the unused length codes, to catch lengths taken from the live inputs or decoded wrongly. A narrow x16 instance checks the page wrap at 8 bits.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Column width for a given device data width
  function automatic int colWidthFor(int dqWidth);
    return (dqWidth == 16) ? 8 : ((dqWidth == 8) ? 9 : 10);
  endfunction

  // Strobes from the control to the address datapath
  typedef struct packed {
    logic       load;       // capture a new start column and mode
    logic       advance;    // step to the next beat
    logic       interleave; // wrap order for the new burst
    logic       fullPage;   // new burst spans the whole page
    logic [1:0] lenLog;     // log2 of the bounded burst length
  } stepCtrl_t;

endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdWrite,
  input  logic [2:0] cfgBurstLen,
  input  logic       cfgInterleave,
  input  logic       cfgSingleWrite,
  output stepCtrl_t  strobe,
  output logic       burstActive,
  output logic       lastBeat
);

  logic       active;
  logic       fullReg;
  logic [2:0] remain;

  logic [1:0] lenLogD;
  logic       fullD;
  logic [2:0] remainD;

  // Decode the length of the incoming command
  always_comb begin
    lenLogD = 2'd0;
    fullD   = 1'b0;
    if (!(cmdWrite && cfgSingleWrite)) begin
      case (cfgBurstLen)
        3'b001:  lenLogD = 2'd1;
        3'b010:  lenLogD = 2'd2;
        3'b011:  lenLogD = 2'd3;
        3'b111:  fullD   = 1'b1;
        default: lenLogD = 2'd0;
      endcase
    end
    case (lenLogD)
      2'd1:    remainD = 3'd1;
      2'd2:    remainD = 3'd3;
      2'd3:    remainD = 3'd7;
      default: remainD = 3'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      fullReg <= 1'b0;
      remain  <= 3'd0;
    end else if (cmdValid) begin
      active  <= 1'b1;
      fullReg <= fullD;
      remain  <= remainD;
    end else if (active && !fullReg) begin
      if (remain == 3'd0) active <= 1'b0;
      else                remain <= remain - 3'd1;
    end
  end

  always_comb begin
    strobe.load       = cmdValid;
    strobe.advance    = !cmdValid && active && (fullReg || (remain != 3'd0));
    strobe.interleave = cfgInterleave;
    strobe.fullPage   = fullD;
    strobe.lenLog     = lenLogD;
  end

  assign burstActive = active;
  assign lastBeat    = active && !fullReg && (remain == 3'd0);

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCtrl_t        strobe,
  input  logic [COL_W-1:0] cmdCol,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] startCol;
  logic [COL_W-1:0] offset;
  logic             ilvReg;
  logic             fullReg;
  logic [1:0]       lenLogReg;

  logic [COL_W-1:0] lowMask;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;
  logic [COL_W-1:0] picked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startCol  <= '0;
      offset    <= '0;
      ilvReg    <= 1'b0;
      fullReg   <= 1'b0;
      lenLogReg <= 2'd0;
    end else if (strobe.load) begin
      startCol  <= cmdCol;
      offset    <= '0;
      ilvReg    <= strobe.interleave;
      fullReg   <= strobe.fullPage;
      lenLogReg <= strobe.lenLog;
    end else if (strobe.advance) begin
      offset    <= offset + 1'b1;
    end
  end

  always_comb begin
    if (fullReg) lowMask = '1;
    else begin
      case (lenLogReg)
        2'd1:    lowMask = COL_W'(3'd1);
        2'd2:    lowMask = COL_W'(3'd3);
        2'd3:    lowMask = COL_W'(3'd7);
        default: lowMask = '0;
      endcase
    end
    seqCol = startCol + offset;
    ilvCol = startCol ^ offset;
    picked = (ilvReg && !fullReg) ? ilvCol : seqCol;
    colOut = (startCol & ~lowMask) | (picked & lowMask);
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int DQ_WIDTH = 4,
  localparam int COL_W = colWidthFor(DQ_WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [COL_W-1:0] cmdCol,
  input  logic [2:0]       cfgBurstLen,
  input  logic             cfgInterleave,
  input  logic             cfgSingleWrite,
  output logic [COL_W-1:0] colOut,
  output logic             burstActive,
  output logic             lastBeat
);

  stepCtrl_t strobe;

  colgen_ctrl ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .cmdValid       (cmdValid),
    .cmdWrite       (cmdWrite),
    .cfgBurstLen    (cfgBurstLen),
    .cfgInterleave  (cfgInterleave),
    .cfgSingleWrite (cfgSingleWrite),
    .strobe         (strobe),
    .burstActive    (burstActive),
    .lastBeat       (lastBeat)
  );

  colgen_addr #(.COL_W(COL_W)) addr_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cmdCol (cmdCol),
    .colOut (colOut)
  );

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [COL_W-1:0] cmdCol,
  input logic [COL_W-1:0] colOut,
  input logic             burstActive,
  input logic             lastBeat
);

  // R10
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> burstActive);

  // R10
  burst_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !cmdValid) |=> !burstActive);

  // R3
  first_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (burstActive && (colOut == $past(cmdCol))));

  // R7
  idle_until_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!burstActive && !cmdValid) |=> !burstActive);

  // R6
  bounded_or_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !lastBeat && !cmdValid) |=> burstActive);

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdCol      (cmdCol),
  .colOut      (colOut),
  .burstActive (burstActive),
  .lastBeat    (lastBeat)
);

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdWrite = 1'b0;
  logic [9:0] cmdCol = '0;
  logic [2:0] cfgBurstLen = 3'b000;
  logic       cfgInterleave = 1'b0;
  logic       cfgSingleWrite = 1'b0;
  logic [9:0] colOut;
  logic       burstActive;
  logic       lastBeat;

  logic       cmdValid16 = 1'b0;
  logic [7:0] cmdCol16 = '0;
  logic [7:0] colOut16;
  logic       burstActive16;
  logic       lastBeat16;

  int checkCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  sdram_burst_colgen #(.DQ_WIDTH(4)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdCol(cmdCol), .cfgBurstLen(cfgBurstLen), .cfgInterleave(cfgInterleave),
    .cfgSingleWrite(cfgSingleWrite), .colOut(colOut),
    .burstActive(burstActive), .lastBeat(lastBeat)
  );

  sdram_burst_colgen #(.DQ_WIDTH(16)) dut16_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid16), .cmdWrite(1'b0),
    .cmdCol(cmdCol16), .cfgBurstLen(3'b111), .cfgInterleave(1'b0),
    .cfgSingleWrite(1'b0), .colOut(colOut16),
    .burstActive(burstActive16), .lastBeat(lastBeat16)
  );

  typedef struct packed {
    logic [9:0]       col;
    logic [2:0]       code;
    logic             ilv;
    logic             wr;
    logic             sw;
    logic [3:0]       nb;
    logic [0:7][9:0]  exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{10'h005, 3'b010, 1'b0, 1'b0, 1'b0, 4'd4, '{10'h005, 10'h006, 10'h007, 10'h004, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{10'h005, 3'b010, 1'b1, 1'b0, 1'b0, 4'd4, '{10'h005, 10'h004, 10'h007, 10'h006, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{10'h0B3, 3'b011, 1'b0, 1'b0, 1'b0, 4'd8, '{10'h0B3, 10'h0B4, 10'h0B5, 10'h0B6, 10'h0B7, 10'h0B0, 10'h0B1, 10'h0B2}},
    '{10'h0B3, 3'b011, 1'b1, 1'b0, 1'b0, 4'd8, '{10'h0B3, 10'h0B2, 10'h0B1, 10'h0B0, 10'h0B7, 10'h0B6, 10'h0B5, 10'h0B4}},
    '{10'h2A1, 3'b001, 1'b0, 1'b0, 1'b0, 4'd2, '{10'h2A1, 10'h2A0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{10'h3FF, 3'b000, 1'b1, 1'b0, 1'b0, 4'd1, '{10'h3FF, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{10'h012, 3'b011, 1'b0, 1'b1, 1'b1, 4'd1, '{10'h012, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{10'h012, 3'b010, 1'b0, 1'b1, 1'b0, 4'd4, '{10'h012, 10'h013, 10'h010, 10'h011, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{10'h012, 3'b010, 1'b0, 1'b0, 1'b1, 4'd4, '{10'h012, 10'h013, 10'h010, 10'h011, 10'h0, 10'h0, 10'h0, 10'h0}},
    '{10'h100, 3'b101, 1'b0, 1'b0, 1'b0, 4'd1, '{10'h100, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0, 10'h0}}
  };
  localparam string TAGS [NV] = '{"R4", "R5", "R4", "R5", "R3", "R3", "R8", "R8", "R8", "R9"};

  task automatic check(string tag, string what, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [9:0] col, logic [2:0] code, logic ilv, logic wr, logic sw);
    cmdValid = 1'b1; cmdCol = col; cfgBurstLen = code;
    cfgInterleave = ilv; cmdWrite = wr; cfgSingleWrite = sw;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "active in reset", int'(burstActive), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "active after reset", int'(burstActive), 0);
    check("R1", "last after reset", int'(lastBeat), 0);
    check("R1", "col after reset", int'(colOut), 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      issue(VECS[v].col, VECS[v].code, VECS[v].ilv, VECS[v].wr, VECS[v].sw);
      @(negedge clk);
      cmdValid = 1'b0;
      for (int b = 0; b < int'(VECS[v].nb); b++) begin
        check(TAGS[v], "col", int'(colOut), int'(VECS[v].exp[b]));
        check(TAGS[v], "active", int'(burstActive), 1);
        check("R10", "last", int'(lastBeat), (b == int'(VECS[v].nb) - 1) ? 1 : 0);
        @(negedge clk);
      end
      check("R10", "active after end", int'(burstActive), 0);
    end

    // R3 settings captured with the command
    issue(10'h005, 3'b010, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmdValid = 1'b0; cfgBurstLen = 3'b000; cfgInterleave = 1'b1;
    check("R3", "beat0 cfg change", int'(colOut), 10'h005);
    @(negedge clk);
    check("R3", "beat1 cfg change", int'(colOut), 10'h006);
    @(negedge clk);
    check("R3", "beat2 cfg change", int'(colOut), 10'h007);
    @(negedge clk);
    check("R3", "beat3 cfg change", int'(colOut), 10'h004);
    check("R3", "last cfg change", int'(lastBeat), 1);
    @(negedge clk);

    // R6 full page with page wrap, interleave ignored
    issue(10'h3FE, 3'b111, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    cmdValid = 1'b0;
    for (int b = 0; b < 1030; b++) begin
      if (b < 5 || b == 1029) begin
        check("R6", "page col", int'(colOut), (10'h3FE + b) % 1024);
        check("R6", "page last", int'(lastBeat), 0);
        check("R6", "page active", int'(burstActive), 1);
      end
      @(negedge clk);
    end
    // R7 new command ends the page burst
    issue(10'h055, 3'b000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmdValid = 1'b0;
    check("R7", "cut page col", int'(colOut), 10'h055);
    check("R7", "cut page last", int'(lastBeat), 1);
    @(negedge clk);
    check("R7", "cut page idle", int'(burstActive), 0);

    // R7 interrupt an 8-beat burst after three beats
    issue(10'h0B3, 3'b011, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7", "beat before cut", int'(colOut), 10'h0B5);
    issue(10'h040, 3'b001, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmdValid = 1'b0;
    check("R7", "new burst beat0", int'(colOut), 10'h040);
    check("R7", "new burst not last", int'(lastBeat), 0);
    @(negedge clk);
    check("R7", "new burst beat1", int'(colOut), 10'h041);
    check("R7", "new burst last", int'(lastBeat), 1);
    @(negedge clk);
    check("R7", "new burst idle", int'(burstActive), 0);

    // R7 one command per clock
    issue(10'h010, 3'b010, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    issue(10'h020, 3'b010, 1'b0, 1'b0, 1'b0);
    check("R7", "b2b col0", int'(colOut), 10'h010);
    @(negedge clk);
    issue(10'h030, 3'b010, 1'b0, 1'b0, 1'b0);
    check("R7", "b2b col1", int'(colOut), 10'h020);
    @(negedge clk);
    cmdValid = 1'b0;
    check("R7", "b2b col2", int'(colOut), 10'h030);
    check("R7", "b2b active", int'(burstActive), 1);
    @(negedge clk);
    check("R7", "b2b continues", int'(colOut), 10'h031);
    repeat (4) @(negedge clk);

    // R2 x16 organisation: 8-bit column wraps at 256
    cmdValid16 = 1'b1; cmdCol16 = 8'hFE;
    @(negedge clk);
    cmdValid16 = 1'b0;
    check("R2", "x16 beat0", int'(colOut16), 8'hFE);
    @(negedge clk);
    check("R2", "x16 beat1", int'(colOut16), 8'hFF);
    @(negedge clk);
    check("R2", "x16 wrap", int'(colOut16), 8'h00);
    check("R2", "x16 active", int'(burstActive16), 1);
    check("R2", "x16 last", int'(lastBeat16), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule